// File: doc/BRIEF.md
# Context-Register Search Key Composer

This block assembles a wide lookup key for a ternary match engine and hands each of several tables its own compacted slice of that key. A bank of context registers holds wide keys, each split into fixed-width segments. On every key-load cycle the caller names one context entry and one segment. The caller either lets the stored segment stand or replaces it with the word on the data bus. A key that is mostly unchanged from an earlier search therefore needs only its changed segments to cross the bus.

When the caller flags the final key-load cycle, the selected context entry is issued as the composed key. That cycle's own overwrite is already included. Each table holds a segment-select mask. The segments it names are packed toward bit 0 in ascending order, and the unused upper part is zero. The packed keys, a segment-count code per table and a one-cycle valid strobe appear one clock after the final key-load cycle. They hold their value until the next issue.

Top module: `ctx_key_composer`

## Requirements
- R1: While reset is asserted and just after it, `keyValid` is 0, all packed keys and all width codes are 0, and every table mask is reset to all ones, so that the first issue without configuration gives every table the full key with width code NUM_SEGS.
- R2: A key-load cycle (`loadValid`=1) with `segWrEn`=1 and a segment code below NUM_SEGS stores `busData` into that segment (segment i occupies bits [i*SEG_W +: SEG_W]) of context entry `ctxSel`.
- R3: A key-load cycle with `segWrEn`=0 leaves the stored segment unchanged, and an issue then uses the stored value.
- R4: On the final key-load cycle (`lastSeg`=1), the issued key is the selected entry with that same cycle's overwrite, if any, already applied.
- R5: A segment code of NUM_SEGS or above never writes, even with `segWrEn`=1. An issue in the same cycle uses the stored entry.
- R6: `keyValid` is high for exactly the one cycle after each cycle with `loadValid`=1 and `lastSeg`=1, and low otherwise. Keys and width codes change only in that cycle.
- R7: For table t, the segments whose mask bit is 1 are packed toward bit 0 in ascending segment order. For example, mask 4'b1001 gives {segment 3, segment 0} in the low two segment slots.
- R8: Key bits above the packed segments are 0. The width code for a table equals the number of ones in its mask, from 0 to NUM_SEGS.
- R9: A cycle with `cfgWrEn`=1 loads `cfgMask` into the mask of table `cfgTable` only. The new mask applies to every issue sampled on a later edge.
- R10: With `loadValid`=0, no context entry is written and no key is issued, whatever the other load inputs are.
- R11: Context entries are independent. A write to one entry never changes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Marks a key-load cycle |
| ctxSel | input | $clog2(DEPTH) | Context entry for this key-load cycle |
| segSel | input | SEG_CODE_W | Segment code for this key-load cycle |
| segWrEn | input | 1 | 1: bus data replaces the selected segment |
| lastSeg | input | 1 | Final key-load cycle; issue the composed key |
| busData | input | SEG_W | Segment data from the bus |
| cfgWrEn | input | 1 | Load a table mask |
| cfgTable | input | $clog2(NUM_TABLES) | Table whose mask is loaded |
| cfgMask | input | NUM_SEGS | New segment mask, bit i selects segment i |
| keyValid | output | 1 | One-cycle strobe: packed keys are new |
| keyOut | output | NUM_TABLES*SEG_W*NUM_SEGS | Packed key of table t at bits [t*SEG_W*NUM_SEGS +: SEG_W*NUM_SEGS] |
| keyWidth | output | NUM_TABLES*$clog2(NUM_SEGS+1) | Segment count of table t's key |

## Verification
The bench builds the block with 8-bit segments, four segments, four context entries and four tables. At that size every context entry can be written through the bus and reissued from storage, and every out-of-range segment code can be tried. All sixteen masks are applied to every table, each table holding a different mask in every round. The narrow segments keep the packed keys short, so the bench computes each expected key directly from its own model of the stored entries and masks.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic segWr;   // write busData into the selected segment
    logic issue;   // capture packed keys this cycle
    logic cfgWr;   // load a table mask
  } ckcStrobes_t;
endpackage

// File: rtl/ckc_ctrl.sv
module ckc_ctrl
  import ckc_pkg::*;
#(
  parameter int NUM_SEGS   = 4,
  parameter int SEG_CODE_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadValid,
  input  logic                  lastSeg,
  input  logic                  segWrEn,
  input  logic [SEG_CODE_W-1:0] segSel,
  input  logic                  cfgWrEn,
  output ckcStrobes_t           strobes,
  output logic                  keyValid
);
  logic segInRange;

  assign segInRange = (segSel < SEG_CODE_W'(NUM_SEGS));

  always_comb begin
    strobes.segWr = loadValid && segWrEn && segInRange;
    strobes.issue = loadValid && lastSeg;
    strobes.cfgWr = cfgWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) keyValid <= 1'b0;
    else       keyValid <= strobes.issue;
  end
endmodule

// File: rtl/ckc_datapath.sv
module ckc_datapath
  import ckc_pkg::*;
#(
  parameter int SEG_W      = 80,
  parameter int NUM_SEGS   = 4,
  parameter int DEPTH      = 128,
  parameter int NUM_TABLES = 4,
  parameter int SEG_CODE_W = 3,
  localparam int KEY_W     = SEG_W * NUM_SEGS,
  localparam int CTX_W     = $clog2(DEPTH),
  localparam int SEG_IDX_W = $clog2(NUM_SEGS),
  localparam int TBL_W     = $clog2(NUM_TABLES),
  localparam int WCODE_W   = $clog2(NUM_SEGS + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ckcStrobes_t                   strobes,
  input  logic [CTX_W-1:0]              ctxSel,
  input  logic [SEG_CODE_W-1:0]         segSel,
  input  logic [SEG_W-1:0]              busData,
  input  logic [TBL_W-1:0]              cfgTable,
  input  logic [NUM_SEGS-1:0]           cfgMask,
  output logic [NUM_TABLES*KEY_W-1:0]   keyOut,
  output logic [NUM_TABLES*WCODE_W-1:0] keyWidth
);
  logic [KEY_W-1:0]    ctxMem [DEPTH];
  logic [NUM_SEGS-1:0] tblMask [NUM_TABLES];
  logic [SEG_IDX_W-1:0] segIdx;
  logic [KEY_W-1:0]    composed;

  assign segIdx = segSel[SEG_IDX_W-1:0];

  // Context bank: one segment written per load cycle
  always_ff @(posedge clk) begin
    if (strobes.segWr) ctxMem[ctxSel][segIdx*SEG_W +: SEG_W] <= busData;
  end

  // Stored entry merged with this cycle's overwrite
  always_comb begin
    composed = ctxMem[ctxSel];
    if (strobes.segWr) composed[segIdx*SEG_W +: SEG_W] = busData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TABLES; t++) tblMask[t] <= '1;
    end else if (strobes.cfgWr) begin
      tblMask[cfgTable] <= cfgMask;
    end
  end

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
    logic [KEY_W-1:0]   packedKey;
    logic [WCODE_W-1:0] packedCnt;

    always_comb begin
      int pos;
      pos = 0;
      packedKey = '0;
      for (int i = 0; i < NUM_SEGS; i++) begin
        if (tblMask[t][i]) begin
          packedKey[pos*SEG_W +: SEG_W] = composed[i*SEG_W +: SEG_W];
          pos = pos + 1;
        end
      end
      packedCnt = WCODE_W'(pos);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        keyOut[t*KEY_W +: KEY_W]       <= '0;
        keyWidth[t*WCODE_W +: WCODE_W] <= '0;
      end else if (strobes.issue) begin
        keyOut[t*KEY_W +: KEY_W]       <= packedKey;
        keyWidth[t*WCODE_W +: WCODE_W] <= packedCnt;
      end
    end
  end
endmodule

// File: rtl/ctx_key_composer.sv
module ctx_key_composer
  import ckc_pkg::*;
#(
  parameter int SEG_W      = 80,
  parameter int NUM_SEGS   = 4,
  parameter int DEPTH      = 128,
  parameter int NUM_TABLES = 4,
  parameter int SEG_CODE_W = 3,
  localparam int KEY_W     = SEG_W * NUM_SEGS,
  localparam int CTX_W     = $clog2(DEPTH),
  localparam int TBL_W     = $clog2(NUM_TABLES),
  localparam int WCODE_W   = $clog2(NUM_SEGS + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          loadValid,
  input  logic [CTX_W-1:0]              ctxSel,
  input  logic [SEG_CODE_W-1:0]         segSel,
  input  logic                          segWrEn,
  input  logic                          lastSeg,
  input  logic [SEG_W-1:0]              busData,
  input  logic                          cfgWrEn,
  input  logic [TBL_W-1:0]              cfgTable,
  input  logic [NUM_SEGS-1:0]           cfgMask,
  output logic                          keyValid,
  output logic [NUM_TABLES*KEY_W-1:0]   keyOut,
  output logic [NUM_TABLES*WCODE_W-1:0] keyWidth
);
  ckcStrobes_t strobes;

  ckc_ctrl #(
    .NUM_SEGS  (NUM_SEGS),
    .SEG_CODE_W(SEG_CODE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadValid(loadValid),
    .lastSeg  (lastSeg),
    .segWrEn  (segWrEn),
    .segSel   (segSel),
    .cfgWrEn  (cfgWrEn),
    .strobes  (strobes),
    .keyValid (keyValid)
  );

  ckc_datapath #(
    .SEG_W     (SEG_W),
    .NUM_SEGS  (NUM_SEGS),
    .DEPTH     (DEPTH),
    .NUM_TABLES(NUM_TABLES),
    .SEG_CODE_W(SEG_CODE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ctxSel  (ctxSel),
    .segSel  (segSel),
    .busData (busData),
    .cfgTable(cfgTable),
    .cfgMask (cfgMask),
    .keyOut  (keyOut),
    .keyWidth(keyWidth)
  );
endmodule

// File: rtl/ckc_checker.sv
module ckc_checker #(
  parameter int SEG_W      = 80,
  parameter int NUM_SEGS   = 4,
  parameter int NUM_TABLES = 4,
  localparam int KEY_W     = SEG_W * NUM_SEGS,
  localparam int WCODE_W   = $clog2(NUM_SEGS + 1)
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          loadValid,
  input logic                          lastSeg,
  input logic                          keyValid,
  input logic [NUM_TABLES*KEY_W-1:0]   keyOut,
  input logic [NUM_TABLES*WCODE_W-1:0] keyWidth
);
  // R6
  strobe_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && lastSeg) |=> keyValid);

  // R6
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadValid && lastSeg) |=> !keyValid);

  // R6
  keys_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadValid && lastSeg) |=> ($stable(keyOut) && $stable(keyWidth)));

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    logic [KEY_W-1:0]   keyT;
    logic [WCODE_W-1:0] wc;
    assign keyT = keyOut[t*KEY_W +: KEY_W];
    assign wc   = keyWidth[t*WCODE_W +: WCODE_W];

    // R8
    width_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      wc <= WCODE_W'(NUM_SEGS));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wc < WCODE_W'(NUM_SEGS)) |-> ((keyT >> (int'(wc) * SEG_W)) == '0));
  end
endmodule

bind ctx_key_composer ckc_checker #(
  .SEG_W     (SEG_W),
  .NUM_SEGS  (NUM_SEGS),
  .NUM_TABLES(NUM_TABLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadValid(loadValid),
  .lastSeg  (lastSeg),
  .keyValid (keyValid),
  .keyOut   (keyOut),
  .keyWidth (keyWidth)
);

// File: tb/ctx_key_composer_bench.sv
module ctx_key_composer_bench;
  localparam int SW = 8;
  localparam int NS = 4;
  localparam int DP = 4;
  localparam int NT = 4;
  localparam int KW = SW * NS;
  localparam int WW = 3;

  logic clk = 1'b0;
  logic rstN;
  logic loadValid;
  logic [1:0] ctxSel;
  logic [2:0] segSel;
  logic segWrEn;
  logic lastSeg;
  logic [SW-1:0] busData;
  logic cfgWrEn;
  logic [1:0] cfgTable;
  logic [NS-1:0] cfgMask;
  logic keyValid;
  logic [NT*KW-1:0] keyOut;
  logic [NT*WW-1:0] keyWidth;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [SW-1:0] model [DP][NS];
  logic [NS-1:0] mMask [NT];

  always #4 clk = ~clk;

  ctx_key_composer #(
    .SEG_W(SW), .NUM_SEGS(NS), .DEPTH(DP), .NUM_TABLES(NT), .SEG_CODE_W(3)
  ) u_ctx_key_composer (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .ctxSel(ctxSel),
    .segSel(segSel), .segWrEn(segWrEn), .lastSeg(lastSeg), .busData(busData),
    .cfgWrEn(cfgWrEn), .cfgTable(cfgTable), .cfgMask(cfgMask),
    .keyValid(keyValid), .keyOut(keyOut), .keyWidth(keyWidth)
  );

  function automatic logic [KW-1:0] expKey(int c, logic [NS-1:0] m);
    logic [KW-1:0] k = '0;
    int p = 0;
    for (int i = 0; i < NS; i++) begin
      if (m[i]) begin
        k[p*SW +: SW] = model[c][i];
        p++;
      end
    end
    return k;
  endfunction

  function automatic int ones(logic [NS-1:0] m);
    int n = 0;
    for (int i = 0; i < NS; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic check(string req, logic [KW-1:0] act, logic [KW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    loadValid = 0; ctxSel = 0; segSel = 0; segWrEn = 0; lastSeg = 0;
    busData = 0; cfgWrEn = 0; cfgTable = 0; cfgMask = 0;
  endtask

  // Drive at negedge, cross one posedge, return at the next negedge
  task automatic step(logic lv, int c, int s, logic wr, logic last, logic [SW-1:0] d);
    loadValid = lv; ctxSel = 2'(c); segSel = 3'(s); segWrEn = wr;
    lastSeg = last; busData = d;
    @(posedge clk);
    @(negedge clk);
    idleInputs();
  endtask

  task automatic cfgWrite(int t, logic [NS-1:0] m);
    cfgWrEn = 1; cfgTable = 2'(t); cfgMask = m;
    @(posedge clk);
    @(negedge clk);
    idleInputs();
    mMask[t] = m;
  endtask

  // Compare all tables against the model for entry c
  task automatic checkKeys(string req, int c);
    check(req, KW'(keyValid), KW'(1'b1));
    for (int t = 0; t < NT; t++) begin
      check(req, keyOut[t*KW +: KW], expKey(c, mMask[t]));
      check(req, KW'(keyWidth[t*WW +: WW]), KW'(ones(mMask[t])));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NT*KW-1:0] held;
    idleInputs();
    rstN = 0;
    for (int t = 0; t < NT; t++) mMask[t] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset outputs
    check("R1", KW'(keyValid), '0);
    check("R1", keyOut[KW-1:0], '0);
    check("R1", KW'(keyWidth), '0);
    rstN = 1;

    // R2 R4 R7 R1: fill every entry over the bus, last flag on final segment
    for (int c = 0; c < DP; c++) begin
      for (int s = 0; s < NS; s++) begin
        model[c][s] = SW'(c * 16 + s * 3 + 1);
        step(1, c, s, 1, s == NS - 1, model[c][s]);
        if (s < NS - 1) check("R6", KW'(keyValid), '0);
      end
      checkKeys("R2/R4", c);
    end

    // R3 R11: reissue each entry from storage only
    for (int c = 0; c < DP; c++) begin
      step(1, c, 0, 0, 1, 8'hFF);
      checkKeys("R3/R11", c);
      held = keyOut;
      step(0, 0, 0, 0, 0, 8'h00);
      // R6 strobe drops and keys hold
      check("R6", KW'(keyValid), '0);
      check("R6", keyOut[KW-1:0], held[KW-1:0]);
    end

    // R5: out-of-range segment codes never write
    for (int s = NS; s < 8; s++) begin
      step(1, 1, s, 1, 1, 8'hEE);
      checkKeys("R5", 1);
    end

    // R10: load inputs ignored without loadValid
    step(0, 2, 1, 1, 1, 8'hC3);
    check("R10", KW'(keyValid), '0);
    step(1, 2, 0, 0, 1, 8'h00);
    checkKeys("R10", 2);

    // R4 mixed: overwrite and issue in the same cycle
    model[2][1] = 8'h5A;
    step(1, 2, 1, 1, 1, 8'h5A);
    checkKeys("R4", 2);
    // R11 neighbours untouched
    step(1, 3, 0, 0, 1, 8'h00);
    checkKeys("R11", 3);

    // R7 R8 R9: every mask on every table, tables differing
    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < NT; t++) cfgWrite(t, 4'((m + 5 * t) % 16));
      step(1, m % DP, 0, 0, 1, 8'h00);
      checkKeys("R7/R8/R9", m % DP);
    end

    // R7 explicit example: mask 1001 on table 0
    cfgWrite(0, 4'b1001);
    step(1, 0, 0, 0, 1, 8'h00);
    check("R7", keyOut[KW-1:0], {16'h0, model[0][3], model[0][0]});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule